// File: doc/BRIEF.md
# Pipeline Slot Tracker with Thread Squash

This block tracks a small, fixed pool of execution slots for one pipeline resource. An instruction presents a request with its thread, sequence number, stage and command. The block answers in the same cycle: either a grant with a slot index, or a deny when no slot is free. A granted slot is held until the instruction releases it. A fixed number of cycles after the grant, the block pulses a completion line for that slot.

Free slots sit in an ordered list, and slots are handed out and taken back in queue order. If an instruction that already owns a slot asks again, it gets its old slot and the stage it recorded the first time. No new slot is taken. A squash port removes every in-flight request of one thread that is younger than a boundary sequence number. It cancels their pending completions and puts their slots back on the list. A kill flag on the same port removes the whole thread. A lookup port finds which slot holds a given sequence number. Two counters report how many slots are free and how many are in use.

Top module: `slot_tracker`

## Requirements
- R1: After reset, avail_o reads N_SLOTS and used_o reads 0. The first N_SLOTS new grants return slot indices 0, 1, 2, 3 in ascending order.
- R2: A new request takes the slot at the head of the free list. A released slot joins the tail, so released slots are granted again in the order they were released.
- R3: A request whose thread and sequence number match a valid slot returns that slot. It drives gnt_again_o high and returns the stage stored at first grant, not the incoming one. The counts do not change and no new completion occurs.
- R4: A new request that finds the free list empty gets deny_o high and gnt_o low. No slot state or count changes.
- R5: done_o[s] pulses for one cycle exactly LATENCY cycles after the cycle in which slot s was newly granted. With LATENCY of zero, the pulse comes in the grant cycle.
- R6: A squash with thread T and boundary S affects each valid slot whose thread is T and whose sequence number is greater than S. Each such slot is flagged on squashed_o in that cycle and loses its pending completion. It is back on the free list in the next cycle.
- R7: With sq_kill_i high, the boundary is taken as zero whatever sq_seq_i says. Every slot of that thread with a nonzero sequence number is squashed. Slots of other threads stay valid.
- R8: lookup_hit_o is high when a valid slot holds lookup_seq_i, and lookup_slot_o is that slot's index. Otherwise lookup_hit_o is low.
- R9: used_o always equals N_SLOTS minus avail_o, and avail_o equals the number of entries on the free list.
- R10: A release and a new request in the same cycle with an empty free list give a deny. The released slot can be granted from the next cycle on.
- R11: Slots squashed in the same cycle join the free list in ascending slot-index order.
- R12: Sequence numbers are 16-bit unsigned values. 0x8000 counts as greater than 0x7FFF. Thread IDs are 2 bits wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_tid_i | input | 2 | Requesting thread |
| req_seq_i | input | 16 | Requesting sequence number |
| req_stage_i | input | 3 | Stage of the request |
| req_cmd_i | input | 4 | Command of the request |
| gnt_o | output | 1 | Request granted this cycle |
| deny_o | output | 1 | Request refused this cycle |
| gnt_again_o | output | 1 | Grant reuses a slot the instruction already held |
| gnt_slot_o | output | IW | Granted slot index |
| gnt_stage_o | output | 3 | Stage attached to the granted slot |
| gnt_cmd_o | output | 4 | Command attached to the granted slot |
| rel_valid_i | input | 1 | Release a slot |
| rel_slot_i | input | IW | Slot to release |
| sq_valid_i | input | 1 | Squash request |
| sq_kill_i | input | 1 | Squash the whole thread (boundary zero) |
| sq_tid_i | input | 2 | Thread to squash |
| sq_seq_i | input | 16 | Squash boundary sequence number |
| squashed_o | output | N_SLOTS | Slots squashed this cycle |
| done_o | output | N_SLOTS | Completion pulse per slot |
| lookup_seq_i | input | 16 | Sequence number to look up |
| lookup_hit_o | output | 1 | Lookup found a valid slot |
| lookup_slot_o | output | IW | Slot holding the looked-up sequence number |
| avail_o | output | CW | Free slots |
| used_o | output | CW | Slots in use |

## Verification
The checks assume the following about the inputs:
- Within one thread, sequence numbers are unique among valid slots.
- A release names only a slot that is currently valid.
- A repeated request never targets a slot that is being released or squashed in the same cycle.

The stimulus gives every request a fresh sequence number and releases only slots it has been granted. It always keeps repeated requests, releases and squashes in separate cycles, except for the one release-plus-request case that R10 covers. Under those conditions the assertions check the following:
- A deny leaves the counts unchanged.
- A fresh grant takes exactly one entry off the free list.
- A squashed slot is invalid in the next cycle.
- No completion follows a cancelled or an already fired one.

// File: rtl/slot_pkg.sv
package slot_pkg;
  parameter int SEQ_W = 16;
  parameter int TID_W = 2;
  parameter int STG_W = 3;
  parameter int CMD_W = 4;

  typedef struct packed {
    logic [TID_W-1:0] tid;
    logic [SEQ_W-1:0] seq;
    logic [STG_W-1:0] stage;
    logic [CMD_W-1:0] cmd;
  } slot_ent_t;
endpackage

// File: rtl/slot_freelist.sv
module slot_freelist #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1,
  localparam int CW = $clog2(N + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pop_i,
  input  logic          rel_push_i,
  input  logic [IW-1:0] rel_idx_i,
  input  logic [N-1:0]  sq_push_i,
  output logic [IW-1:0] head_o,
  output logic [CW-1:0] cnt_o
);
  logic [N-1:0][IW-1:0] fl_q, fl_d;
  logic [CW-1:0]        cnt_q, cnt_d;

  // pop from head first, then append release, then squashed slots low to high
  always_comb begin
    fl_d  = fl_q;
    cnt_d = cnt_q;
    if (pop_i) begin
      for (int i = 0; i < N - 1; i++) fl_d[i] = fl_q[i+1];
      cnt_d = cnt_d - CW'(1);
    end
    if (rel_push_i && cnt_d < CW'(N)) begin
      fl_d[cnt_d[IW-1:0]] = rel_idx_i;
      cnt_d = cnt_d + CW'(1);
    end
    for (int i = 0; i < N; i++) begin
      if (sq_push_i[i] && cnt_d < CW'(N)) begin
        fl_d[cnt_d[IW-1:0]] = IW'(i);
        cnt_d = cnt_d + CW'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N; i++) fl_q[i] <= IW'(i);
      cnt_q <= CW'(N);
    end else begin
      fl_q  <= fl_d;
      cnt_q <= cnt_d;
    end
  end

  assign head_o = fl_q[0];
  assign cnt_o  = cnt_q;

  p_cnt_bound_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(N));
  p_pop_nonempty_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> cnt_q != '0);
endmodule

// File: rtl/slot_match.sv
module slot_match #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]                     valid_i,
  input  logic [N-1:0][slot_pkg::TID_W-1:0] tid_i,
  input  logic [N-1:0][slot_pkg::SEQ_W-1:0] seq_i,
  input  logic                             care_tid_i,
  input  logic [slot_pkg::TID_W-1:0]       key_tid_i,
  input  logic [slot_pkg::SEQ_W-1:0]       key_seq_i,
  output logic                             hit_o,
  output logic [IW-1:0]                    idx_o
);
  // lowest matching index wins
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (valid_i[i] && seq_i[i] == key_seq_i &&
          (!care_tid_i || tid_i[i] == key_tid_i)) begin
        hit_o = 1'b1;
        idx_o = IW'(i);
      end
    end
  end
endmodule

// File: rtl/slot_timer.sv
module slot_timer #(
  parameter int N       = 4,
  parameter int LATENCY = 2,
  localparam int TW = $clog2(LATENCY + 1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] start_i,
  input  logic [N-1:0] cancel_i,
  output logic [N-1:0] done_o
);
  logic [N-1:0]         pend_q;
  logic [N-1:0][TW-1:0] tmr_q;

  for (genvar g = 0; g < N; g++) begin : g_slot
    assign done_o[g] = pend_q[g] && tmr_q[g] == TW'(1);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pend_q[g] <= 1'b0;
        tmr_q[g]  <= '0;
      end else if (start_i[g]) begin
        pend_q[g] <= 1'b1;
        tmr_q[g]  <= TW'(LATENCY);
      end else if (cancel_i[g] || done_o[g]) begin
        pend_q[g] <= 1'b0;
      end else if (pend_q[g]) begin
        tmr_q[g]  <= tmr_q[g] - TW'(1);
      end
    end

    p_single_done_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o[g] |=> !done_o[g]);
    p_cancel_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cancel_i[g] |=> !done_o[g]);
  end
endmodule

// File: rtl/slot_tracker.sv
module slot_tracker
  import slot_pkg::*;
#(
  parameter int N_SLOTS = 4,
  parameter int LATENCY = 2,
  localparam int IW = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1,
  localparam int CW = $clog2(N_SLOTS + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  input  logic [TID_W-1:0]   req_tid_i,
  input  logic [SEQ_W-1:0]   req_seq_i,
  input  logic [STG_W-1:0]   req_stage_i,
  input  logic [CMD_W-1:0]   req_cmd_i,
  output logic               gnt_o,
  output logic               deny_o,
  output logic               gnt_again_o,
  output logic [IW-1:0]      gnt_slot_o,
  output logic [STG_W-1:0]   gnt_stage_o,
  output logic [CMD_W-1:0]   gnt_cmd_o,
  input  logic               rel_valid_i,
  input  logic [IW-1:0]      rel_slot_i,
  input  logic               sq_valid_i,
  input  logic               sq_kill_i,
  input  logic [TID_W-1:0]   sq_tid_i,
  input  logic [SEQ_W-1:0]   sq_seq_i,
  output logic [N_SLOTS-1:0] squashed_o,
  output logic [N_SLOTS-1:0] done_o,
  input  logic [SEQ_W-1:0]   lookup_seq_i,
  output logic               lookup_hit_o,
  output logic [IW-1:0]      lookup_slot_o,
  output logic [CW-1:0]      avail_o,
  output logic [CW-1:0]      used_o
);
  logic [N_SLOTS-1:0]             valid_q;
  slot_ent_t                      ent_q [N_SLOTS];
  logic [N_SLOTS-1:0][TID_W-1:0]  tid_a;
  logic [N_SLOTS-1:0][SEQ_W-1:0]  seq_a;
  logic                           rr_hit;
  logic [IW-1:0]                  rr_idx, head;
  logic [CW-1:0]                  fcnt;
  logic                           alloc, rel_ok;
  logic [SEQ_W-1:0]               bound;
  logic [N_SLOTS-1:0]             sq_vec, rel_vec, alloc_vec;

  always_comb begin
    for (int i = 0; i < N_SLOTS; i++) begin
      tid_a[i] = ent_q[i].tid;
      seq_a[i] = ent_q[i].seq;
    end
  end

  slot_match #(.N(N_SLOTS)) u_rereq (
    .valid_i(valid_q), .tid_i(tid_a), .seq_i(seq_a), .care_tid_i(1'b1),
    .key_tid_i(req_tid_i), .key_seq_i(req_seq_i), .hit_o(rr_hit), .idx_o(rr_idx)
  );

  slot_match #(.N(N_SLOTS)) u_lookup (
    .valid_i(valid_q), .tid_i(tid_a), .seq_i(seq_a), .care_tid_i(1'b0),
    .key_tid_i('0), .key_seq_i(lookup_seq_i), .hit_o(lookup_hit_o),
    .idx_o(lookup_slot_o)
  );

  assign alloc       = req_valid_i && !rr_hit && fcnt != '0;
  assign gnt_o       = req_valid_i && (rr_hit || fcnt != '0);
  assign deny_o      = req_valid_i && !rr_hit && fcnt == '0;
  assign gnt_again_o = req_valid_i && rr_hit;
  assign gnt_slot_o  = rr_hit ? rr_idx : head;
  assign gnt_stage_o = rr_hit ? ent_q[rr_idx].stage : req_stage_i;
  assign gnt_cmd_o   = rr_hit ? ent_q[rr_idx].cmd : req_cmd_i;

  assign bound = sq_kill_i ? '0 : sq_seq_i;

  always_comb begin
    for (int i = 0; i < N_SLOTS; i++) begin
      sq_vec[i] = sq_valid_i && valid_q[i] && ent_q[i].tid == sq_tid_i &&
                  ent_q[i].seq > bound;
      alloc_vec[i] = alloc && head == IW'(i);
    end
    rel_ok  = rel_valid_i && valid_q[rel_slot_i] && !sq_vec[rel_slot_i];
    rel_vec = '0;
    rel_vec[rel_slot_i] = rel_ok;
  end

  assign squashed_o = sq_vec;

  slot_freelist #(.N(N_SLOTS)) u_free (
    .clk_i, .rst_ni, .pop_i(alloc), .rel_push_i(rel_ok), .rel_idx_i(rel_slot_i),
    .sq_push_i(sq_vec), .head_o(head), .cnt_o(fcnt)
  );

  if (LATENCY > 0) begin : g_timed
    slot_timer #(.N(N_SLOTS), .LATENCY(LATENCY)) u_timer (
      .clk_i, .rst_ni, .start_i(alloc_vec), .cancel_i(sq_vec | rel_vec),
      .done_o(done_o)
    );
  end else begin : g_instant
    assign done_o = alloc_vec & ~(sq_vec | rel_vec);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      for (int i = 0; i < N_SLOTS; i++) ent_q[i] <= '0;
    end else begin
      for (int i = 0; i < N_SLOTS; i++) begin
        if (sq_vec[i] || rel_vec[i]) valid_q[i] <= 1'b0;
        else if (alloc_vec[i]) begin
          valid_q[i] <= 1'b1;
          ent_q[i]   <= '{tid: req_tid_i, seq: req_seq_i,
                          stage: req_stage_i, cmd: req_cmd_i};
        end
      end
    end
  end

  assign avail_o = fcnt;
  assign used_o  = CW'(N_SLOTS) - fcnt;

  p_deny_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    deny_o && !rel_valid_i && !sq_valid_i |=> avail_o == $past(avail_o));
  p_alloc_take_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_o && !gnt_again_o && !rel_valid_i && !sq_valid_i
      |=> avail_o == $past(avail_o) - CW'(1));
  p_again_valid_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_again_o |-> valid_q[gnt_slot_o]);
  p_lookup_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lookup_hit_o |-> valid_q[lookup_slot_o] && ent_q[lookup_slot_o].seq == lookup_seq_i);
  for (genvar g = 0; g < N_SLOTS; g++) begin : g_chk
    p_squash_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      squashed_o[g] |=> !valid_q[g]);
  end
endmodule

// File: tb/slot_tracker_bench.sv
`timescale 1ns/1ps
module slot_tracker_bench;
  localparam int N = 4;
  localparam int LAT = 2;

  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic        req_valid = 0, rel_valid = 0, sq_valid = 0, sq_kill = 0;
  logic [1:0]  req_tid = 0, sq_tid = 0, rel_slot = 0;
  logic [15:0] req_seq = 0, sq_seq = 0, lookup_seq = 0;
  logic [2:0]  req_stage = 0;
  logic [3:0]  req_cmd = 0;
  logic        gnt, deny, again, lk_hit;
  logic [1:0]  gslot, lk_slot;
  logic [2:0]  gstage, avail, used;
  logic [3:0]  gcmd, sqd, done;

  slot_tracker #(.N_SLOTS(N), .LATENCY(LAT)) u_slot_tracker (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_tid_i(req_tid),
    .req_seq_i(req_seq), .req_stage_i(req_stage), .req_cmd_i(req_cmd),
    .gnt_o(gnt), .deny_o(deny), .gnt_again_o(again), .gnt_slot_o(gslot),
    .gnt_stage_o(gstage), .gnt_cmd_o(gcmd), .rel_valid_i(rel_valid),
    .rel_slot_i(rel_slot), .sq_valid_i(sq_valid), .sq_kill_i(sq_kill),
    .sq_tid_i(sq_tid), .sq_seq_i(sq_seq), .squashed_o(sqd), .done_o(done),
    .lookup_seq_i(lookup_seq), .lookup_hit_o(lk_hit), .lookup_slot_o(lk_slot),
    .avail_o(avail), .used_o(used)
  );

  int nchk = 0, nfail = 0, cyc = 0;
  int done_n [N];
  int done_at [N];
  int gnt_at [N];
  bit c_gnt, c_deny, c_again;
  int c_slot, c_stage, c_sqd;

  always @(posedge clk) cyc = cyc + 1;
  initial for (int s = 0; s < N; s++) begin done_n[s] = 0; done_at[s] = -1; gnt_at[s] = -1; end
  always @(negedge clk) for (int s = 0; s < N; s++) if (done[s]) begin
    done_n[s]++; done_at[s] = cyc;
  end

  task automatic chk(string r, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", r, act, exp);
    end
  endtask

  task automatic op(bit rq, int t, int s, int st, bit rl, int rs,
                    bit sq, bit kl, int sqt, int sqs);
    @(negedge clk);
    req_valid = rq; req_tid = 2'(t); req_seq = 16'(s); req_stage = 3'(st);
    req_cmd = 4'(s);
    rel_valid = rl; rel_slot = 2'(rs);
    sq_valid = sq; sq_kill = kl; sq_tid = 2'(sqt); sq_seq = 16'(sqs);
    #1;
    c_gnt = gnt; c_deny = deny; c_again = again;
    c_slot = gslot; c_stage = gstage; c_sqd = sqd;
    if (gnt && !again) gnt_at[gslot] = cyc;
    @(posedge clk); #1;
    req_valid = 0; rel_valid = 0; sq_valid = 0; sq_kill = 0;
  endtask

  task automatic req(int t, int s, int st); op(1, t, s, st, 0, 0, 0, 0, 0, 0); endtask
  task automatic rel(int rs); op(0, 0, 0, 0, 1, rs, 0, 0, 0, 0); endtask
  task automatic squash(bit kl, int t, int s); op(0, 0, 0, 0, 0, 0, 1, kl, t, s); endtask
  task automatic idle(int n); repeat (n) @(negedge clk); #1; endtask

  task automatic grant_exp(string r, int t, int s, int exp_slot);
    req(t, s, 1);
    chk(r, c_gnt, 1);
    chk(r, c_slot, exp_slot);
  endtask

  initial begin
    #(200000 * 5);
    nfail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    int pre;
    #12 rst_n = 1;
    idle(1);
    // R1 reset state
    chk("R1 avail", avail, N);
    chk("R1 used", used, 0);
    chk("R1 done", done, 0);
    // R1/R2 ascending first grants, R9 counts
    for (int k = 0; k < N; k++) begin
      req(0, 10 + k, k + 1);
      chk("R1 gnt", c_gnt, 1);
      chk("R1 slot", c_slot, k);
      chk("R9 avail", avail, N - 1 - k);
      chk("R9 used", used, k + 1);
    end
    // R5 latency
    idle(3);
    for (int s = 0; s < N; s++) begin
      chk("R5 count", done_n[s], 1);
      chk("R5 delay", done_at[s] - gnt_at[s], LAT);
    end
    // R3 re-request returns stored slot and stage
    req(0, 12, 7);
    chk("R3 gnt", c_gnt, 1);
    chk("R3 again", c_again, 1);
    chk("R3 slot", c_slot, 2);
    chk("R3 stage", c_stage, 3);
    chk("R3 avail", avail, 0);
    idle(3);
    chk("R3 no new done", done_n[2], 1);
    // R4 deny when empty
    req(1, 50, 0);
    chk("R4 deny", c_deny, 1);
    chk("R4 nognt", c_gnt, 0);
    chk("R4 avail", avail, 0);
    chk("R4 used", used, N);
    // R8 lookup
    lookup_seq = 11; #1;
    chk("R8 hit", lk_hit, 1);
    chk("R8 slot", lk_slot, 1);
    lookup_seq = 99; #1;
    chk("R8 miss", lk_hit, 0);
    // R10 release + request while empty
    op(1, 1, 51, 2, 1, 1, 0, 0, 0, 0);
    chk("R10 deny", c_deny, 1);
    chk("R10 avail", avail, 1);
    grant_exp("R10 regrant", 1, 51, 1);
    // R2 FIFO reuse order
    rel(3);
    rel(0);
    chk("R9 avail2", avail, 2);
    grant_exp("R2 fifo first", 2, 60, 3);
    grant_exp("R2 fifo second", 2, 61, 0);
    // R6 squash younger of thread 2
    squash(0, 2, 60);
    chk("R6 flags", c_sqd, 4'b0001);
    chk("R6 freed", avail, 1);
    pre = done_n[0];
    grant_exp("R6 regrant", 2, 70, 0);
    squash(0, 2, 65);
    chk("R6 flags2", c_sqd, 4'b0001);
    idle(4);
    chk("R6 cancelled done", done_n[0], pre);
    // R7 kill thread 1 (boundary ignored) and R11 ascending return
    grant_exp("R7 setup", 1, 40, 0);
    squash(1, 1, 16'hFFFF);
    chk("R7 flags", c_sqd, 4'b0011);
    chk("R7 avail", avail, 2);
    lookup_seq = 12; #1;
    chk("R7 other thread kept", lk_hit, 1);
    grant_exp("R11 order first", 3, 16'h8000, 0);
    grant_exp("R11 order second", 3, 16'h7FFF, 1);
    // R12 unsigned compare
    squash(0, 3, 16'h7FFF);
    chk("R12 flags", c_sqd, 4'b0001);
    chk("R12 avail", avail, 1);
    // R7 kill remaining threads -> list [0,2,3,1]
    squash(1, 0, 0);
    squash(1, 2, 0);
    squash(1, 3, 0);
    chk("R7 all free", avail, N);
    chk("R9 none used", used, 0);
    grant_exp("R2 order a", 0, 300, 0);
    grant_exp("R2 order b", 0, 301, 2);
    grant_exp("R2 order c", 0, 302, 3);
    grant_exp("R2 order d", 0, 303, 1);
    // R2 sweep over rotated release orders
    for (int rot = 0; rot < N; rot++) begin
      for (int k = 0; k < N; k++) rel((rot + k) % N);
      chk("R9 sweep avail", avail, N);
      for (int k = 0; k < N; k++)
        grant_exp("R2 sweep", 0, 400 + rot * N + k, (rot + k) % N);
    end
    idle(3);
    for (int s = 0; s < N; s++) chk("R5 sweep delay", done_at[s] - gnt_at[s], LAT);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule